// File: doc/BRIEF.md
# Four-lane interleaved 1:8 deserializer

This block takes four serial lanes that share one fast bit clock and turns them into one 32-bit parallel word. Each lane supplies eight consecutive bits to every word. Lane k fills the output positions k, k+4, k+8 and so on up to k+28, so the lanes interleave at a stride of four. Every eight bit clocks a new word appears on the parallel output, and it then holds steady for the next full word period.

A word clock at one eighth of the bit rate goes out next to the data. A 2-bit select sets where that clock sits relative to the word boundary, in quarter-period steps of two bit clocks each. Downstream logic can then pick an edge that is clear of the data transition.

The block is free-running and does not need a reset at power-up. A synchronous reset exists for test. It puts the bit counter at position zero, so a tester knows which serial bit begins the next word.

Top module: `quad_interleave_deser`

## Requirements
- R1: Lane k (ser_in[k]) feeds par_out bits k+4j for j = 0..7, and feeds no other bit.
- R2: Within each group of eight bits on a lane, bit j in time order (j = 0 first) lands on par_out[k+4j]. The first bit therefore goes to the lane's lowest output.
- R3: par_out changes only on the rising bit-clock edge that samples the eighth bit of a group. All 32 bits change together on that edge, and par_out then stays unchanged for the next seven edges.
- R4: word_clk has a period of eight bit clocks, with four cycles high and four cycles low.
- R5: phase_sel sets the delay of word_clk. With phase_sel = 2'b00, word_clk goes high on the same edge that updates par_out. Each quarter step delays word_clk by two more bit clocks: 2'b11 delays it by 2, 2'b10 by 4 (word_clk falls as par_out updates), and 2'b01 by 6.
- R6: A synchronous active-high rst clears par_out and the bit counter. The first rising edge with rst low samples bit 0 of a new group. While rst is high, word_clk holds the level it would have at group position 0 for the current phase_sel.
- R7: phase_sel has no effect on the content or timing of par_out. A change to phase_sel takes effect on word_clk from the next clock edge, and the word grouping is not disturbed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, shared by all lanes |
| rst | input | 1 | Synchronous active-high test reset |
| ser_in | input | 4 | One serial bit per lane, sampled on each rising clk edge |
| phase_sel | input | 2 | Selects the word clock delay in quarter-period steps |
| par_out | output | 32 | Registered parallel word, interleaved at a stride of four |
| word_clk | output | 1 | Registered word clock at clk/8 |

## Verification
A walking one is sent through every one of the 32 output positions. If the stride or the time order were reversed, the single set bit would come out at the wrong index, for example bit 28 instead of bit 0. The bench checks par_out on every cycle, not only at the word boundary, so a design that updated the holding register early or on each shift would show partial words mid-period. word_clk is compared cycle by cycle for all four select codes, including a change of select on the fly; a swapped 90/270 encoding shows up as a four-cycle offset. A reset three bits into a word then checks that the counter realigns, because a design that failed to clear the counter would rotate the lane bits between output positions.

// File: rtl/qdes_pkg.sv
`timescale 1ns/1ps
package qdes_pkg;

  // Number of quarter-period delay steps selected by the 2-bit phase code.
  typedef logic [1:0] quarter_t;

  function automatic quarter_t phase_steps(input logic [1:0] sel);
    quarter_t q;
    case (sel)
      2'b00:   q = 2'd0;  // 0 degrees
      2'b11:   q = 2'd1;  // 90 degrees
      2'b10:   q = 2'd2;  // 180 degrees
      default: q = 2'd3;  // 270 degrees
    endcase
    return q;
  endfunction

endpackage

// File: rtl/qdes_lane.sv
`timescale 1ns/1ps
module qdes_lane #(
  parameter int RATIO = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ser,
  output logic [RATIO-1:0] word_nxt
);

  // The oldest bit sits at index 0. RATIO-1 bits are stored, and the
  // current serial bit completes the group.
  logic [RATIO-2:0] sreg;

  assign word_nxt = {ser, sreg};

  always_ff @(posedge clk) begin
    if (rst) sreg <= '0;
    else     sreg <= word_nxt[RATIO-1:1];
  end

endmodule

// File: rtl/qdes_sequencer.sv
`timescale 1ns/1ps
module qdes_sequencer
  import qdes_pkg::*;
#(
  parameter int RATIO = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] phase_sel,
  output logic       load,
  output logic       word_clk
);

  localparam int CW   = $clog2(RATIO);
  localparam int HALF = RATIO / 2;
  localparam int STEP = RATIO / 4;

  logic [CW-1:0] cnt;       // position of the next bit to be sampled
  logic [CW-1:0] cnt_nxt;
  logic [CW-1:0] shifted;

  assign load = (cnt == CW'(RATIO - 1));

  always_comb begin
    if (rst || load) cnt_nxt = '0;
    else             cnt_nxt = cnt + 1'b1;
    shifted = cnt_nxt - (CW'(STEP) * CW'(phase_steps(phase_sel)));
  end

  always_ff @(posedge clk) begin
    cnt      <= cnt_nxt;
    word_clk <= (shifted < CW'(HALF));
  end

  // R6: reset puts the group position at zero
  p_reset_pos_r6: assert property (@(posedge clk) rst |=> (cnt == '0));

  // R5: at zero delay, word_clk rises as the word completes
  p_zero_phase_r5: assert property (@(posedge clk) disable iff (rst)
    (load && phase_sel == 2'b00 && $stable(phase_sel)) |=> $rose(word_clk));

  // R5: at half-period delay, word_clk falls as the word completes
  p_half_phase_r5: assert property (@(posedge clk) disable iff (rst)
    (load && phase_sel == 2'b10 && $stable(phase_sel)) |=> $fell(word_clk));

endmodule

// File: rtl/quad_interleave_deser.sv
`timescale 1ns/1ps
module quad_interleave_deser #(
  parameter int LANES = 4,
  parameter int RATIO = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [LANES-1:0]       ser_in,
  input  logic [1:0]             phase_sel,
  output logic [LANES*RATIO-1:0] par_out,
  output logic                   word_clk
);

  localparam int WIDTH = LANES * RATIO;

  logic             load;
  logic [WIDTH-1:0] par_nxt;

  qdes_sequencer #(.RATIO(RATIO)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .phase_sel (phase_sel),
    .load      (load),
    .word_clk  (word_clk)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [RATIO-1:0] lane_word;

    qdes_lane #(.RATIO(RATIO)) u_lane (
      .clk      (clk),
      .rst      (rst),
      .ser      (ser_in[k]),
      .word_nxt (lane_word)
    );

    // Bit j in time order of lane k lands at position k + LANES*j
    for (genvar j = 0; j < RATIO; j++) begin : g_bit
      assign par_nxt[k + LANES*j] = lane_word[j];
    end

    // R1: the newest bit of a lane reaches that lane's highest output
    p_last_bit_r1: assert property (@(posedge clk) disable iff (rst)
      load |=> (par_out[LANES*(RATIO-1) + k] == $past(ser_in[k])));
  end

  always_ff @(posedge clk) begin
    if (rst)       par_out <= '0;
    else if (load) par_out <= par_nxt;
  end

  // R3: the holding register changes only at a word boundary
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(par_out));

endmodule

// File: tb/test_quad_interleave_deser.sv
`timescale 1ns/1ps
module test_quad_interleave_deser;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  ser_in = '0;
  logic [1:0]  phase_sel = 2'b00;
  logic [31:0] par_out;
  logic        word_clk;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] exp_par = '0;

  always #2.5 clk = ~clk;  // 200 MHz

  quad_interleave_deser i_quad_interleave_deser (
    .clk       (clk),
    .rst       (rst),
    .ser_in    (ser_in),
    .phase_sel (phase_sel),
    .par_out   (par_out),
    .word_clk  (word_clk)
  );

  function automatic logic model_wclk(input int pos, input logic [1:0] sel);
    int s;
    case (sel)
      2'b00: s = 0;
      2'b11: s = 1;
      2'b10: s = 2;
      default: s = 3;
    endcase
    return ((pos - 2*s + 16) % 8) < 4;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Called at a negedge; leaves the bench at a negedge.
  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    exp_par = '0;
    chk("R6 par_out in reset", par_out, '0);
    chk("R6 word_clk in reset", {31'b0, word_clk}, {31'b0, model_wclk(0, phase_sel)});
    rst = 1'b0;
  endtask

  // Sends one word; lane k bit j carries w[4j+k] (R1, R2). Checks every cycle (R3, R4, R5).
  task automatic send_word(input logic [31:0] w);
    for (int j = 0; j < 8; j++) begin
      for (int k = 0; k < 4; k++) ser_in[k] = w[4*j + k];
      @(posedge clk);
      @(negedge clk);
      if (j == 7) exp_par = w;
      chk("R1/R2/R3 par_out", par_out, exp_par);
      chk("R4/R5 word_clk", {31'b0, word_clk}, {31'b0, model_wclk((j + 1) % 8, phase_sel)});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();

    // R1, R2: a walking one through all 32 output positions
    for (int b = 0; b < 32; b++) send_word(32'h1 << b);

    // Each lane alone, all ones, all zeros
    send_word(32'h1111_1111);
    send_word(32'h2222_2222);
    send_word(32'h4444_4444);
    send_word(32'h8888_8888);
    send_word(32'hFFFF_FFFF);
    send_word(32'h0000_0000);

    // R5, R7: sweep all four phase codes with arithmetic data
    for (int p = 0; p < 4; p++) begin
      phase_sel = p[1:0];
      do_reset();
      for (int i = 0; i < 12; i++)
        send_word((i + 1) * 32'h9E37_79B9 ^ (p * 32'h0F0F_1234));
    end

    // R7: change the phase between words without reset
    for (int p = 0; p < 4; p++) begin
      phase_sel = 2'(3 - p);
      send_word(32'hA5C3_0000 + p);
      send_word(~(32'hA5C3_0000 + p));
    end

    // R6: reset part-way through a word realigns the grouping
    phase_sel = 2'b00;
    for (int j = 0; j < 3; j++) begin
      ser_in = 4'hF;
      @(posedge clk);
      @(negedge clk);
    end
    do_reset();
    send_word(32'h0000_0001);
    send_word(32'h8000_0000);
    send_word(32'h1234_5678);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule